// File: doc/BRIEF.md
# FIFO Threshold Request Controller

This block sits next to a pair of 64-byte FIFOs, one for received data and one for data to transmit. It does not hold any data. Each cycle it reads the current fill level of both FIFOs, the pop strobe of the receive side and the push strobe of the transmit side. It also reads the programmed trigger fields, the FIFO-enable control and the DMA-enable control. From these it drives two interrupt lines and two DMA request lines.

A request is raised and dropped by different rules. The receive interrupt follows the fill level against the receive trigger. The transmit interrupt is set when its FIFO is empty and is cleared once the fill level reaches the transmit trigger. Each DMA request starts on a level condition. It is then held until a fixed number of bytes has moved: pops for receive, pushes for transmit. A short transfer therefore leaves the request active.

When the FIFOs are disabled, every trigger falls back to one byte, so DMA moves single characters. All four outputs are registered and react one clock after their inputs.

Top module: `fifo_req_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four outputs are 0 after that edge.
- R2: A trigger field value N from 1 to 15 selects 4*N bytes, and a value of 0 selects 1 byte. While `fifo_en` is 0, both the receive and transmit triggers are 1 byte, regardless of the fields.
- R3: One cycle after any input cycle, `rx_irq` is 1 exactly when `rx_level` was at or above the receive trigger.
- R4: `tx_irq` becomes 1 the cycle after `tx_level` is 0. It becomes 0 the cycle after `tx_level` is at or above the transmit trigger. In all other cycles it holds its value.
- R5: With `dma_en` at 1 and no receive request pending, `rx_dma_req` rises the cycle after `rx_level` is at or above the receive trigger.
- R6: An active `rx_dma_req` counts the `rx_pop` pulses seen while it is high. It falls the cycle after the pulse that makes the count equal to the receive trigger. Fewer pulses leave it high.
- R7: With `dma_en` at 1 and no transmit request pending, `tx_dma_req` rises the cycle after `tx_level` is below the transmit DMA threshold. With `fifo_en` at 0, that threshold is 1, so the request starts only on an empty FIFO.
- R8: An active `tx_dma_req` counts the `tx_push` pulses seen while it is high. It falls the cycle after the pulse that makes the count equal to the transmit trigger (the trigger spaces). Fewer pulses leave it high.
- R9: With `fifo_en` at 1 and `tx_thr_explicit` at 0, the transmit DMA threshold is 64 minus the transmit trigger spaces.
- R10: With `fifo_en` at 1 and `tx_thr_explicit` at 1, the transmit DMA threshold is `tx_thr_value`. If `tx_thr_value` plus the trigger spaces exceeds 64, the threshold is 64 instead.
- R11: The cycle after `dma_en` is 0, both DMA requests are 0, and their byte counts restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_en | input | 1 | FIFOs enabled; 0 forces one-byte triggers |
| dma_en | input | 1 | DMA requests allowed; 0 is the mode with DMA lines idle |
| rx_trig | input | 4 | Receive trigger field |
| tx_trig | input | 4 | Transmit trigger field (spaces) |
| tx_thr_explicit | input | 1 | Use `tx_thr_value` as the transmit DMA threshold |
| tx_thr_value | input | 7 | Programmed transmit DMA threshold |
| rx_level | input | 7 | Receive FIFO fill level, 0 to 64 |
| tx_level | input | 7 | Transmit FIFO fill level, 0 to 64 |
| rx_pop | input | 1 | One byte read from the receive FIFO this cycle |
| tx_push | input | 1 | One byte written to the transmit FIFO this cycle |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_irq | output | 1 | Transmit interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The checker assumes the fill levels never exceed 64. It also assumes strobes are plain one-cycle pulses that the surrounding FIFO reflects in its level, though the block itself never checks the two against each other. The stimulus keeps every level between 0 and 64. It changes the trigger fields and the threshold option only while the related request is idle, or while DMA is off. Strobes appear only in cycles where a request is meant to count them.

// File: rtl/fifo_req_pkg.sv
package fifo_req_pkg;

    localparam int FIFO_DEPTH = 64;
    localparam int TRIG_W     = 4;
    localparam int TRIG_SCALE = 4;
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);

    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [TRIG_W-1:0] trig_t;

    typedef struct packed {
        level_t rx_thr;
        level_t tx_thr;
        level_t tx_dma_thr;
    } thr_set_t;

    // Trigger field to byte count; zero field or disabled FIFO gives one byte.
    function automatic level_t trig_to_bytes(trig_t field, logic en);
        if (!en || field == '0)
            return level_t'(1);
        return level_t'(field) * level_t'(TRIG_SCALE);
    endfunction

    // Transmit DMA threshold from the explicit value or from the free space.
    function automatic level_t tx_dma_limit(logic explicit_sel, level_t value, level_t spaces);
        logic [LVL_W:0] sum;
        sum = {1'b0, value} + {1'b0, spaces};
        if (!explicit_sel)
            return level_t'(FIFO_DEPTH) - spaces;
        if (sum > (LVL_W+1)'(FIFO_DEPTH))
            return level_t'(FIFO_DEPTH);
        return value;
    endfunction

endpackage

// File: rtl/fifo_req_thresh.sv
module fifo_req_thresh
    import fifo_req_pkg::*;
(
    input  logic     fifo_en,
    input  trig_t    rx_trig,
    input  trig_t    tx_trig,
    input  logic     tx_thr_explicit,
    input  level_t   tx_thr_value,
    output thr_set_t thr
);
    always_comb begin
        thr.rx_thr     = trig_to_bytes(rx_trig, fifo_en);
        thr.tx_thr     = trig_to_bytes(tx_trig, fifo_en);
        thr.tx_dma_thr = fifo_en ? tx_dma_limit(tx_thr_explicit, tx_thr_value, thr.tx_thr)
                                 : level_t'(1);
    end
endmodule

// File: rtl/fifo_req_irq.sv
module fifo_req_irq
    import fifo_req_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  level_t   rx_level,
    input  level_t   tx_level,
    input  thr_set_t thr,
    output logic     rx_irq,
    output logic     tx_irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_irq <= 1'b0;
            tx_irq <= 1'b0;
        end else begin
            rx_irq <= (rx_level >= thr.rx_thr);
            if (tx_level == '0)
                tx_irq <= 1'b1;
            else if (tx_level >= thr.tx_thr)
                tx_irq <= 1'b0;
        end
    end
endmodule

// File: rtl/fifo_req_dma_chan.sv
module fifo_req_dma_chan
    import fifo_req_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   start,
    input  logic   strobe,
    input  level_t target,
    output logic   req
);
    level_t         moved;
    logic [LVL_W:0] moved_next;

    always_comb moved_next = {1'b0, moved} + (LVL_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            req   <= 1'b0;
            moved <= '0;
        end else if (!req) begin
            moved <= '0;
            if (start)
                req <= 1'b1;
        end else if (strobe) begin
            if (moved_next >= {1'b0, target}) begin
                req   <= 1'b0;
                moved <= '0;
            end else begin
                moved <= level_t'(moved_next);
            end
        end
    end
endmodule

// File: rtl/fifo_req_ctrl.sv
module fifo_req_ctrl
    import fifo_req_pkg::*;
#(
    parameter int N_CHAN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              dma_en,
    input  logic [TRIG_W-1:0] rx_trig,
    input  logic [TRIG_W-1:0] tx_trig,
    input  logic              tx_thr_explicit,
    input  logic [LVL_W-1:0]  tx_thr_value,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              rx_pop,
    input  logic              tx_push,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              rx_dma_req,
    output logic              tx_dma_req
);
    localparam int CH_RX = 0;
    localparam int CH_TX = 1;

    thr_set_t           thr;
    logic [N_CHAN-1:0]  ch_start;
    logic [N_CHAN-1:0]  ch_strobe;
    logic [N_CHAN-1:0]  ch_req;
    level_t             ch_target [N_CHAN];

    fifo_req_thresh u_thresh (
        .fifo_en         (fifo_en),
        .rx_trig         (rx_trig),
        .tx_trig         (tx_trig),
        .tx_thr_explicit (tx_thr_explicit),
        .tx_thr_value    (tx_thr_value),
        .thr             (thr)
    );

    fifo_req_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .thr      (thr),
        .rx_irq   (rx_irq),
        .tx_irq   (tx_irq)
    );

    always_comb begin
        ch_start[CH_RX]   = (rx_level >= thr.rx_thr);
        ch_strobe[CH_RX]  = rx_pop;
        ch_target[CH_RX]  = thr.rx_thr;
        ch_start[CH_TX]   = (tx_level < thr.tx_dma_thr);
        ch_strobe[CH_TX]  = tx_push;
        ch_target[CH_TX]  = thr.tx_thr;
    end

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        fifo_req_dma_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .enable (dma_en),
            .start  (ch_start[g]),
            .strobe (ch_strobe[g]),
            .target (ch_target[g]),
            .req    (ch_req[g])
        );
    end

    assign rx_dma_req = ch_req[CH_RX];
    assign tx_dma_req = ch_req[CH_TX];
endmodule

// File: rtl/fifo_req_ctrl_chk.sv
module fifo_req_ctrl_chk
    import fifo_req_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fifo_en,
    input logic              dma_en,
    input logic [TRIG_W-1:0] rx_trig,
    input logic [TRIG_W-1:0] tx_trig,
    input logic              tx_thr_explicit,
    input logic [LVL_W-1:0]  tx_thr_value,
    input logic [LVL_W-1:0]  rx_level,
    input logic [LVL_W-1:0]  tx_level,
    input logic              rx_pop,
    input logic              tx_push,
    input logic              rx_irq,
    input logic              tx_irq,
    input logic              rx_dma_req,
    input logic              tx_dma_req
);
    level_t rx_bytes;
    level_t tx_space;
    level_t tx_lim;

    always_comb begin
        rx_bytes = trig_to_bytes(rx_trig, fifo_en);
        tx_space = trig_to_bytes(tx_trig, fifo_en);
        tx_lim   = fifo_en ? tx_dma_limit(tx_thr_explicit, tx_thr_value, tx_space) : level_t'(1);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !rx_irq && !tx_irq && !rx_dma_req && !tx_dma_req);

    // R3
    rx_irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rx_irq == $past(rx_level >= rx_bytes));

    // R4
    tx_irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_irq) |-> $past(tx_level) == '0);

    // R5
    rx_dma_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_dma_req) |-> $past(dma_en) && $past(rx_level >= rx_bytes));

    // R6
    rx_dma_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(rx_dma_req)) |-> $past(rx_pop) || !$past(dma_en));

    // R7
    tx_dma_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_dma_req) |-> $past(dma_en) && $past(tx_level < tx_lim));

    // R8
    tx_dma_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(tx_dma_req)) |-> $past(tx_push) || !$past(dma_en));

    // R11
    dma_off_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(dma_en) |-> !rx_dma_req && !tx_dma_req);
endmodule

bind fifo_req_ctrl fifo_req_ctrl_chk u_chk (.*);

// File: tb/fifo_req_ctrl_bench.sv
module fifo_req_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_en, dma_en, tx_thr_explicit, rx_pop, tx_push;
    logic [3:0] rx_trig, tx_trig;
    logic [6:0] tx_thr_value, rx_level, tx_level;
    logic       rx_irq, tx_irq, rx_dma_req, tx_dma_req;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_req_ctrl u_fifo_req_ctrl (.*);

    // {fifo_en, rx_trig, rx_level, expected rx_irq}
    localparam int NV = 13;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 4'd0,  7'd0,  1'b0}, {1'b1, 4'd0,  7'd1,  1'b1},
        {1'b1, 4'd1,  7'd3,  1'b0}, {1'b1, 4'd1,  7'd4,  1'b1},
        {1'b1, 4'd3,  7'd11, 1'b0}, {1'b1, 4'd3,  7'd12, 1'b1},
        {1'b1, 4'd15, 7'd59, 1'b0}, {1'b1, 4'd15, 7'd60, 1'b1},
        {1'b1, 4'd15, 7'd64, 1'b1}, {1'b0, 4'd15, 7'd1,  1'b1},
        {1'b0, 4'd15, 7'd0,  1'b0}, {1'b1, 4'd8,  7'd32, 1'b1},
        {1'b1, 4'd8,  7'd31, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; fifo_en = 1'b1; dma_en = 1'b1; tx_thr_explicit = 1'b0;
        rx_pop = 1'b0; tx_push = 1'b0; rx_trig = '0; tx_trig = '0;
        tx_thr_value = '0; rx_level = 7'd64; tx_level = 7'd0;
        tick(); tick();
        // R1: outputs quiet under reset despite active conditions
        check(rx_irq, 1'b0, "R1 rx_irq");
        check(tx_irq, 1'b0, "R1 tx_irq");
        check(rx_dma_req, 1'b0, "R1 rx_dma_req");
        check(tx_dma_req, 1'b0, "R1 tx_dma_req");
        dma_en = 1'b0; rst = 1'b0; tx_level = 7'd32; rx_level = '0;
        tick();

        // R3 / R2: receive interrupt against decoded trigger
        for (int i = 0; i < NV; i++) begin
            {fifo_en, rx_trig, rx_level} = VEC[i][12:1];
            tick();
            check(rx_irq, VEC[i][0], "R3/R2 rx_irq table");
        end

        // R4: transmit interrupt hysteresis, trigger 8 bytes
        fifo_en = 1'b1; tx_trig = 4'd2; rx_level = '0;
        tx_level = 7'd0; tick(); check(tx_irq, 1'b1, "R4 set on empty");
        tx_level = 7'd5; tick(); check(tx_irq, 1'b1, "R4 hold below trigger");
        tx_level = 7'd8; tick(); check(tx_irq, 1'b0, "R4 clear at trigger");
        tx_level = 7'd3; tick(); check(tx_irq, 1'b0, "R4 hold cleared");
        tx_level = 7'd0; tick(); check(tx_irq, 1'b1, "R4 set again");

        // R5 / R6: receive DMA, trigger 4 bytes
        tx_level = 7'd64; dma_en = 1'b1; rx_trig = 4'd1;
        rx_level = 7'd3; tick(); check(rx_dma_req, 1'b0, "R5 below trigger");
        check(tx_dma_req, 1'b0, "R7 level above threshold");
        rx_level = 7'd4; tick(); check(rx_dma_req, 1'b1, "R5 start at trigger");
        for (int i = 0; i < 3; i++) begin
            rx_pop = 1'b1; rx_level = 7'(3 - i);
            tick(); check(rx_dma_req, 1'b1, "R6 short read keeps request");
        end
        rx_level = 7'd0; tick(); check(rx_dma_req, 1'b0, "R6 drop after last pop");
        rx_pop = 1'b0;
        tick(); check(rx_dma_req, 1'b0, "R6 stays low");

        // R9 / R7 / R8: implicit threshold 64-60 = 4
        tx_trig = 4'd15;
        tx_level = 7'd4; tick(); check(tx_dma_req, 1'b0, "R9 level at threshold");
        tx_level = 7'd3; tick(); check(tx_dma_req, 1'b1, "R9 level below threshold");
        tx_level = 7'd10; tx_push = 1'b1;
        for (int i = 0; i < 59; i++) begin
            tick(); check(tx_dma_req, 1'b1, "R8 partial fill keeps request");
        end
        tick(); check(tx_dma_req, 1'b0, "R8 drop after 60 pushes");
        tx_push = 1'b0;
        tick(); check(tx_dma_req, 1'b0, "R8 stays low");

        // R11: DMA disabled keeps requests low
        dma_en = 1'b0; rx_level = 7'd64; tx_level = 7'd0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(rx_dma_req, 1'b0, "R11 rx idle");
            check(tx_dma_req, 1'b0, "R11 tx idle");
        end

        // R10: explicit threshold, clamp 50+16>64 gives 64
        rx_level = '0; tx_thr_explicit = 1'b1; tx_thr_value = 7'd50; tx_trig = 4'd4;
        tx_level = 7'd63; dma_en = 1'b1;
        tick(); check(tx_dma_req, 1'b1, "R10 clamped threshold");
        dma_en = 1'b0; tick(); check(tx_dma_req, 1'b0, "R11 drop on disable");
        tx_thr_value = 7'd10; tx_level = 7'd10; dma_en = 1'b1;
        tick(); check(tx_dma_req, 1'b0, "R10 level at explicit value");
        tx_level = 7'd9;
        tick(); check(tx_dma_req, 1'b1, "R10 level below explicit value");
        tx_level = 7'd20; tx_push = 1'b1;
        for (int i = 0; i < 15; i++) begin
            tick(); check(tx_dma_req, 1'b1, "R8 16-space partial");
        end
        tick(); check(tx_dma_req, 1'b0, "R8 16-space drop");
        tx_push = 1'b0;

        // R2 / R7: FIFOs disabled, single-character DMA
        dma_en = 1'b0; tick();
        fifo_en = 1'b0; tx_thr_explicit = 1'b0; tx_trig = 4'd15; rx_trig = 4'd15;
        tx_level = 7'd1; rx_level = 7'd0; dma_en = 1'b1;
        tick(); check(tx_dma_req, 1'b0, "R7 disabled fifo not empty");
        tx_level = 7'd0;
        tick(); check(tx_dma_req, 1'b1, "R7 disabled fifo empty");
        tx_push = 1'b1; tx_level = 7'd1;
        tick(); check(tx_dma_req, 1'b0, "R2 single push ends request");
        tx_push = 1'b0;
        tick(); check(tx_dma_req, 1'b0, "R2 tx stays low");
        rx_level = 7'd1;
        tick(); check(rx_dma_req, 1'b1, "R2 rx single char start");
        rx_pop = 1'b1; rx_level = 7'd0;
        tick(); check(rx_dma_req, 1'b0, "R2 single pop ends request");
        rx_pop = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule